// File: doc/BRIEF.md
# Watchdog and Supply Reset Supervisor

This block produces an active-low reset for a processor from two sources of trouble: a supply rail that has dropped out of regulation, and software that has stopped servicing its watchdog. The supply is seen through two digital comparator flags. One flag reports that the rail has fallen under the lower threshold. The other reports that it has climbed over the upper threshold. Between the two thresholds the block keeps its previous verdict, which gives hysteresis.

While the rail is low, reset is held. Once the rail recovers, reset stays low for one programmed delay and is then released. From then on the processor must pull its watchdog strobe from high to low at least once per delay. If it misses the window, the block emits an endless square-wave reset train: low for one delay, then high for one delay. The train stops as soon as a valid falling edge arrives. The power-on hold, the watchdog window and each half-period of the train all use the same delay register value. That value is counted in ticks of a clock-enable timebase.

Top module: `wdt_reset_supervisor`

## Requirements
- R1: While the latched supply state is low, `rst_out_n` is 0. An assertion of `vdd_below_lo` is reflected on `rst_out_n` no later than two clock edges after it is sampled.
- R2: The latched supply state turns low only on `vdd_below_lo` = 1, and turns good only on `vdd_above_hi` = 1 with `vdd_below_lo` = 0. With both flags at 0, the latched state does not change.
- R3: After the supply turns good, `rst_out_n` stays 0 for `dly_ticks` ticks and then goes to 1. With a tick on every cycle and `dly_ticks` = 8, it rises on the 10th clock edge after `vdd_above_hi` is first sampled high.
- R4: Only a high-to-low transition of `wd_in`, after a two-flop synchronizer, counts as service. It restarts the watchdog window. Holding `wd_in` low or raising it does not.
- R5: If no service edge arrives within `dly_ticks` ticks of the window start, `rst_out_n` goes to 0 and the reset train begins.
- R6: The train is a 50% square wave: `rst_out_n` is 0 for `dly_ticks` ticks, then 1 for `dly_ticks` ticks, and this repeats.
- R7: A service edge during the train ends it. `rst_out_n` returns to 1 and a fresh window starts.
- R8: Service edges that occur while the supply is low, or during the power-on hold, have no effect on the timing.
- R9: A supply-low event during the train takes priority. The block restarts the full power-on sequence instead of continuing the train.
- R10: The delay counter advances only on cycles where `tick` is 1. With `tick` held at 0, no timed phase ever ends.
- R11: A synchronous `rst_n` = 0 puts the block into the supply-low state with `rst_out_n` = 0. After that, a full power-on hold is needed before release. A `dly_ticks` value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset of the block |
| tick | input | 1 | Timebase enable; the delay counter advances on it |
| dly_ticks | input | CNT_W | Programmed delay in ticks |
| vdd_below_lo | input | 1 | Comparator flag: rail under the lower threshold |
| vdd_above_hi | input | 1 | Comparator flag: rail over the upper threshold |
| wd_in | input | 1 | Watchdog strobe from the processor, asynchronous |
| rst_out_n | output | 1 | Active-low reset to the processor |

## Verification
The assertions assume the two comparator flags are never both 1 for long. A rail cannot be under the lower threshold and over the upper one at once. The stimulus never raises both flags together. The assertions also assume `dly_ticks` stays constant while a phase is being timed. The bench changes it only across a block reset, and the vector table runs with a fixed delay of 8 and a tick on every cycle, so that every edge count can be stated exactly. The watchdog strobe is driven between clock edges and held for at least two cycles, so the synchronizer always sees it.

// File: rtl/sup_pkg.sv
// Shared types for the reset supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package sup_pkg;
    // Sequencer phases; the output is high only in SQ_RUN and SQ_TRN_HI.
    typedef enum logic [2:0] {
        SQ_HOLD   = 3'd0,
        SQ_POR    = 3'd1,
        SQ_RUN    = 3'd2,
        SQ_TRN_LO = 3'd3,
        SQ_TRN_HI = 3'd4
    } sq_state_t;
endpackage

// File: rtl/wd_edge_sync.sv
// Synchronizes the asynchronous watchdog strobe through two flops and
// flags one-cycle high-to-low transitions of the synchronized value.
// Assumes: the strobe holds each level for at least two clock cycles.
// The flops reset to 1, as an undriven pin would read through a pull-up.
module wd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_async,
    output logic wd_fall
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Shift the strobe through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], wd_async};
    end

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[LAST];
    end

    assign wd_fall = prev_q & ~sync_q[LAST];

    // R4: a detected edge is preceded by a high synchronized level
    a_r4_edge_from_high: assert property (@(posedge clk) disable iff (!rst_n)
        wd_fall |-> $past(sync_q[LAST]));
endmodule

// File: rtl/supply_hyst.sv
// Latches a supply-good verdict from two comparator flags with hysteresis:
// the low flag forces "bad", the high flag (alone) restores "good".
// Assumes: the two flags are not both set for long; low wins if they are.
module supply_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic below_lo,
    input  logic above_hi,
    output logic sup_ok
);
    // Update the latched verdict; hold it between thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n)                              sup_ok <= 1'b0;
        else if (below_lo)                       sup_ok <= 1'b0;
        else if (!sup_ok && above_hi)            sup_ok <= 1'b1;
    end

    // R2: good stays good until the low flag
    a_r2_hold_good: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_ok && !below_lo) |=> sup_ok);
    // R2: bad stays bad until the high flag
    a_r2_hold_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_ok && !above_hi) |=> !sup_ok);
endmodule

// File: rtl/sup_sequencer.sv
// Phase sequencer and shared delay counter: power-on hold, watchdog window
// and square-wave reset train, all timed by one programmed tick count.
// Assumes: dly_ticks is stable while a phase is timed; 0 behaves as 1.
module sup_sequencer
    import sup_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] dly_ticks,
    input  logic             sup_ok,
    input  logic             wd_fall,
    output logic             rst_out_n
);
    localparam int EXT_W = CNT_W + 1;

    sq_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             expire;

    // A phase ends on the tick that completes dly_ticks counts.
    assign expire = tick && ((EXT_W'(cnt_q) + EXT_W'(1)) >= EXT_W'(dly_ticks));

    // Next-phase choice; supply loss beats everything, service beats expiry.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!sup_ok) begin
            state_d = SQ_HOLD;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                SQ_HOLD: begin
                    state_d = SQ_POR;
                    cnt_d   = '0;
                end
                SQ_POR: begin
                    if (expire)    begin state_d = SQ_RUN; cnt_d = '0; end
                    else if (tick) cnt_d = cnt_q + 1'b1;
                end
                SQ_RUN, SQ_TRN_LO, SQ_TRN_HI: begin
                    if (wd_fall) begin
                        state_d = SQ_RUN;
                        cnt_d   = '0;
                    end else if (expire) begin
                        state_d = (state_q == SQ_TRN_LO) ? SQ_TRN_HI : SQ_TRN_LO;
                        cnt_d   = '0;
                    end else if (tick) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = SQ_HOLD;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // Register phase and counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output is released only in the service window and the train's high half.
    assign rst_out_n = (state_q == SQ_RUN) || (state_q == SQ_TRN_HI);

    // R1: a bad supply verdict pulls the output low on the next edge
    a_r1_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_ok |=> !rst_out_n);
    // R10: without a tick the power-on hold cannot end
    a_r10_no_tick_no_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_POR && sup_ok && !tick) |=> (state_q == SQ_POR));
    // R8: service edges do not shorten the power-on hold
    a_r8_por_ignores_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_POR && sup_ok && wd_fall && !expire) |=> !rst_out_n);
    // R4: service in the window restarts it
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_RUN && sup_ok && wd_fall) |=> (rst_out_n && cnt_q == '0));
    // R7: service during the train releases the output
    a_r7_train_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == SQ_TRN_LO || state_q == SQ_TRN_HI) && sup_ok && wd_fall) |=> rst_out_n);
    // R6: a train half ends only on expiry, service or supply loss
    a_r6_half_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_TRN_LO && sup_ok && !wd_fall && !expire) |=> !rst_out_n);
endmodule

// File: rtl/wdt_reset_supervisor.sv
// Top of the reset supervisor: ties the watchdog synchronizer, the supply
// hysteresis latch and the phase sequencer together.
// Assumes: comparator flags are already synchronous to clk.
module wdt_reset_supervisor #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] dly_ticks,
    input  logic             vdd_below_lo,
    input  logic             vdd_above_hi,
    input  logic             wd_in,
    output logic             rst_out_n
);
    logic wd_fall;
    logic sup_ok;

    wd_edge_sync #(.SYNC_STAGES(2)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .wd_async (wd_in),
        .wd_fall  (wd_fall)
    );

    supply_hyst u_hyst (
        .clk      (clk),
        .rst_n    (rst_n),
        .below_lo (vdd_below_lo),
        .above_hi (vdd_above_hi),
        .sup_ok   (sup_ok)
    );

    sup_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .dly_ticks (dly_ticks),
        .sup_ok    (sup_ok),
        .wd_fall   (wd_fall),
        .rst_out_n (rst_out_n)
    );

    // R11: block reset leaves the output low on the following edge
    a_r11_block_reset: assert property (@(posedge clk)
        !rst_n |=> !rst_out_n);
endmodule

// File: tb/wdt_reset_supervisor_test.sv
module wdt_reset_supervisor_test;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b1;
    logic [CNT_W-1:0] dly_ticks = 16'd8;
    logic             lo_f = 1'b1;
    logic             hi_f = 1'b0;
    logic             wd = 1'b1;
    logic             rst_out_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wdt_reset_supervisor #(.CNT_W(CNT_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .dly_ticks    (dly_ticks),
        .vdd_below_lo (lo_f),
        .vdd_above_hi (hi_f),
        .wd_in        (wd),
        .rst_out_n    (rst_out_n)
    );

    typedef struct packed {
        logic       lo;
        logic       hi;
        logic       wd;
        logic [7:0] cyc;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 26;
    // Delay 8, tick every cycle; each row is applied at a falling clock edge,
    // run for cyc rising edges, then the output is compared.
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b1, 8'd3, 1'b0, 4'd1},  // R1 supply low
        '{1'b0, 1'b0, 1'b1, 8'd5, 1'b0, 4'd2},  // R2 between thresholds: stays low
        '{1'b0, 1'b1, 1'b1, 8'd9, 1'b0, 4'd3},  // R3 power-on hold
        '{1'b0, 1'b1, 1'b1, 8'd1, 1'b1, 4'd3},  // R3 release on 10th edge
        '{1'b0, 1'b1, 1'b1, 8'd4, 1'b1, 4'd4},  // R4 window running
        '{1'b0, 1'b1, 1'b0, 8'd3, 1'b1, 4'd4},  // R4 falling edge restarts
        '{1'b0, 1'b1, 1'b1, 8'd6, 1'b1, 4'd4},  // R4 rising edge ignored
        '{1'b0, 1'b1, 1'b1, 8'd1, 1'b1, 4'd5},  // R5 last cycle of window
        '{1'b0, 1'b1, 1'b1, 8'd1, 1'b0, 4'd5},  // R5 window missed
        '{1'b0, 1'b1, 1'b1, 8'd7, 1'b0, 4'd6},  // R6 low half
        '{1'b0, 1'b1, 1'b1, 8'd1, 1'b1, 4'd6},  // R6 high half starts
        '{1'b0, 1'b1, 1'b1, 8'd7, 1'b1, 4'd6},  // R6 high half
        '{1'b0, 1'b1, 1'b1, 8'd1, 1'b0, 4'd6},  // R6 next low half
        '{1'b0, 1'b1, 1'b0, 8'd2, 1'b0, 4'd7},  // R7 edge in synchronizer
        '{1'b0, 1'b1, 1'b0, 8'd1, 1'b1, 4'd7},  // R7 train ended
        '{1'b1, 1'b0, 1'b1, 8'd2, 1'b0, 4'd1},  // R1 supply drops
        '{1'b1, 1'b0, 1'b0, 8'd4, 1'b0, 4'd8},  // R8 edge while supply low
        '{1'b0, 1'b1, 1'b1, 8'd4, 1'b0, 4'd8},  // R8 hold, strobe high
        '{1'b0, 1'b1, 1'b0, 8'd5, 1'b0, 4'd8},  // R8 edge during hold ignored
        '{1'b0, 1'b1, 1'b0, 8'd1, 1'b1, 4'd8},  // R8 release on time
        '{1'b0, 1'b1, 1'b0, 8'd7, 1'b1, 4'd4},  // R4 held low is no service
        '{1'b0, 1'b1, 1'b0, 8'd1, 1'b0, 4'd5},  // R5 train starts
        '{1'b1, 1'b0, 1'b0, 8'd2, 1'b0, 4'd9},  // R9 supply low in train
        '{1'b0, 1'b1, 1'b0, 8'd9, 1'b0, 4'd9},  // R9 full hold, not train high
        '{1'b0, 1'b1, 1'b0, 8'd1, 1'b1, 4'd9},  // R9 released after hold
        '{1'b0, 1'b1, 1'b0, 8'd3, 1'b1, 4'd4}   // R4 still inside window
    };

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic exp, input int req);
        n_chk++;
        if (rst_out_n !== exp) begin
            n_fail++;
            $display("FAIL R%0d: rst_out_n=%b expected %b at %0t", req, rst_out_n, exp, $time);
        end
    endtask

    initial begin
        @(negedge clk);
        run(3);
        check(1'b0, 11);  // R11 output low in block reset
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            lo_f = VEC[i].lo;
            hi_f = VEC[i].hi;
            wd   = VEC[i].wd;
            run(int'(VEC[i].cyc));
            check(VEC[i].exp, int'(VEC[i].req));
        end

        // R10: no tick, no end of power-on hold
        wd = 1'b1; lo_f = 1'b1; hi_f = 1'b0;
        run(2);
        tick = 1'b0; lo_f = 1'b0; hi_f = 1'b1;
        run(40);
        check(1'b0, 10);
        tick = 1'b1;
        run(7);
        check(1'b0, 10);
        run(1);
        check(1'b1, 10);

        // R11: block reset while running forces a full hold again
        rst_n = 1'b0;
        run(1);
        check(1'b0, 11);
        rst_n = 1'b1;
        run(9);
        check(1'b0, 11);
        run(1);
        check(1'b1, 11);

        // R11: delay 0 acts as 1 (window of one tick)
        dly_ticks = '0;
        rst_n = 1'b0;
        run(1);
        rst_n = 1'b1;
        run(3);
        check(1'b1, 11);
        run(1);
        check(1'b0, 11);
        run(1);
        check(1'b1, 11);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule